// File: doc/BRIEF.md
# Precision-Time Port Role Controller

This block holds the role of one port of a precision time protocol node. It chooses among six roles: disabled, listening, pre-master, master, slave and passive. It reacts to three things: a strobe for each Sync frame received, a strobe carrying the verdict of an external best-master comparison, and a port enable. Three programmable cycle counts set the timing: how long the port listens, how long it stays in pre-master, and the interval between Sync transmissions.

Once enabled, the port listens for Sync traffic. If none arrives in time, it first claims mastership quietly as pre-master, with no Sync output. If it still hears nothing, it becomes an active master and requests a Sync transmission at a fixed period. If Sync traffic is heard, the timeouts stop and the best-master verdict decides the role. While the port is slave, it raises a flag that allows the local clock to be corrected. Frame parsing, timestamps and the dataset comparison itself lie outside the block.

Top module: `ptp_port_fsm`

## Requirements
- R1: While reset is held and in the first cycle after it, the port reports disabled, and `sync_tx`, `corr_en` and `master_role` are all low.
- R2: A disabled port moves to listening at the clock edge where `enable` is high and was low in the previous cycle (the first edge after reset counts as such a rise). If `enable` stays high, the port remains disabled.
- R3: A listening port that hears no Sync moves to pre-master after exactly `listen_cycles` cycles in listening. A count of 0 acts as 1.
- R4: Once a Sync strobe is seen in listening or pre-master, the timeout no longer applies. The next `bmc_valid` strobe, which may come in the same cycle as the Sync, sets the role. A `bmc_valid` strobe arriving before any Sync in these two roles is ignored.
- R5: In pre-master, `master_role` is high and `sync_tx` stays low. With no Sync heard, the port becomes master after exactly `qual_cycles` cycles there (0 acts as 1).
- R6: In master, `sync_tx` is a pulse that lasts one cycle. It comes every `sync_period` cycles (0 acts as 1), the first one in the `sync_period`-th cycle of master. It is never high outside master.
- R7: `corr_en` is high exactly while the port is slave.
- R8: In master, slave or passive, a `bmc_valid` strobe selects the next role from `bmc_code`: 0 master, 1 slave, 2 passive, 3 disabled. Sync strobes have no effect in these roles.
- R9: Deasserting `enable` forces disabled at the next edge from any role and clears the timers and the heard-Sync memory.
- R10: `port_state` uses the encoding 0 disabled, 1 listening, 2 pre-master, 3 master, 4 slave, 5 passive. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port enable |
| sync_rx | input | 1 | Sync frame received strobe |
| bmc_valid | input | 1 | Best-master verdict strobe |
| bmc_code | input | 2 | Verdict: 0 master, 1 slave, 2 passive, 3 disabled |
| listen_cycles | input | CW | Listening timeout in cycles |
| qual_cycles | input | CW | Pre-master timeout in cycles |
| sync_period | input | CW | Cycles between Sync requests |
| port_state | output | 3 | Current role code |
| sync_tx | output | 1 | One-cycle Sync transmit request |
| corr_en | output | 1 | Offset correction allowed |
| master_role | output | 1 | Port reports master status (pre-master or master) |

## Verification
Any role change caused by a strobe or by a timeout shows on `port_state` one clock edge after the cycle in which the strobe was presented or the final timeout cycle ran. `sync_tx`, `corr_en` and `master_role` are decoded from registered state, so they follow in the same cycle as the role they belong to. The bench applies each cycle's inputs at the falling edge and compares every output 1 ns later, before the next rising edge. That makes every comparison see the outputs produced by the previous edge. The directed walks count cycles from role entry to land exactly on each timeout and on each Sync pulse.

// File: rtl/ptp_port_fsm.sv
module ptp_port_fsm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sync_rx,
  input  logic          bmc_valid,
  input  logic [1:0]    bmc_code,
  input  logic [CW-1:0] listen_cycles,
  input  logic [CW-1:0] qual_cycles,
  input  logic [CW-1:0] sync_period,
  output logic [2:0]    port_state,
  output logic          sync_tx,
  output logic          corr_en,
  output logic          master_role
);
  localparam logic [2:0] S_DIS = 3'd0, S_LIS = 3'd1, S_PRE = 3'd2,
                         S_MST = 3'd3, S_SLV = 3'd4, S_PAS = 3'd5;

  logic [CW-1:0] tmr;
  logic          heard, en_q;
  logic [2:0]    nxt, verdict;
  logic [CW:0]   tcnt;
  logic          lis_done, qual_done, per_done, heard_now;

  assign tcnt      = {1'b0, tmr} + 1'b1;
  assign lis_done  = tcnt >= {1'b0, listen_cycles} && tcnt != '0;
  assign qual_done = tcnt >= {1'b0, qual_cycles};
  assign per_done  = tcnt >= {1'b0, sync_period};
  assign heard_now = heard | sync_rx;

  always_comb begin
    case (bmc_code)
      2'd0:    verdict = S_MST;
      2'd1:    verdict = S_SLV;
      2'd2:    verdict = S_PAS;
      default: verdict = S_DIS;
    endcase
  end

  always_comb begin
    nxt = port_state;
    case (port_state)
      S_DIS: if (enable && !en_q) nxt = S_LIS;
      S_LIS: if (heard_now && bmc_valid) nxt = verdict;
             else if (!heard_now && lis_done) nxt = S_PRE;
      S_PRE: if (heard_now && bmc_valid) nxt = verdict;
             else if (!heard_now && qual_done) nxt = S_MST;
      S_MST, S_SLV, S_PAS: if (bmc_valid) nxt = verdict;
      default: nxt = S_DIS;
    endcase
    if (!enable) nxt = S_DIS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_state <= S_DIS;
      tmr        <= '0;
      heard      <= 1'b0;
      en_q       <= 1'b0;
    end else begin
      en_q       <= enable;
      port_state <= nxt;
      if (nxt != port_state) begin
        tmr   <= '0;
        heard <= 1'b0;
      end else begin
        if (port_state == S_LIS || port_state == S_PRE) begin
          heard <= heard_now;
          tmr   <= tmr + 1'b1;
        end else if (port_state == S_MST) begin
          tmr   <= per_done ? '0 : tmr + 1'b1;
        end
      end
    end
  end

  assign sync_tx     = (port_state == S_MST) && per_done;
  assign corr_en     = (port_state == S_SLV);
  assign master_role = (port_state == S_PRE) || (port_state == S_MST);
endmodule

// File: rtl/ptp_port_fsm_chk.sv
module ptp_port_fsm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          sync_rx,
  input logic [CW-1:0] sync_period,
  input logic [2:0]    port_state,
  input logic          sync_tx,
  input logic          corr_en,
  input logic          master_role
);
  p_tx_in_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_tx |-> port_state == 3'd3);

  p_tx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_tx |=> (!sync_tx || sync_period <= 1));

  p_corr_not_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_en |-> !master_role);

  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> port_state == 3'd0);

  p_pre_from_listen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_state == 3'd2 && $past(port_state) != 3'd2) |-> $past(port_state) == 3'd1);

  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_state <= 3'd5);
endmodule

bind ptp_port_fsm ptp_port_fsm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_rx(sync_rx),
  .sync_period(sync_period), .port_state(port_state), .sync_tx(sync_tx),
  .corr_en(corr_en), .master_role(master_role)
);

// File: tb/tb_ptp_port_fsm.sv
`timescale 1ns/1ps
module tb_ptp_port_fsm;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, srx = 1'b0, bv = 1'b0;
  logic [1:0] code = 2'd0;
  logic [CW-1:0] lis = 16'd5, qul = 16'd4, per = 16'd3;
  logic [2:0] st;
  logic tx, corr, role;
  int nvec = 0, nbad = 0;
  int ms = 0, mt = 0, mh = 0, me = 0;

  always #10 clk = ~clk;

  ptp_port_fsm #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(en), .sync_rx(srx), .bmc_valid(bv),
    .bmc_code(code), .listen_cycles(lis), .qual_cycles(qul), .sync_period(per),
    .port_state(st), .sync_tx(tx), .corr_en(corr), .master_role(role));

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int vstate(input logic [1:0] c);
    return (c == 0) ? 3 : (c == 1) ? 4 : (c == 2) ? 5 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic s, input logic b,
                     input logic [1:0] c, input string tag);
    int ns, nt, nh, hn;
    en = e; srx = s; bv = b; code = c;
    #1;
    chk({tag, " state"}, int'(st), ms);
    chk({tag, " sync_tx"}, int'(tx), int'(ms == 3 && mt + 1 >= eff(per)));
    chk({tag, " corr_en"}, int'(corr), int'(ms == 4));
    chk({tag, " master_role"}, int'(role), int'(ms == 2 || ms == 3));
    hn = mh | int'(s);
    ns = ms;
    case (ms)
      0: if (e && !me) ns = 1;
      1: if (hn && b) ns = vstate(c); else if (!hn && mt + 1 >= eff(lis)) ns = 2;
      2: if (hn && b) ns = vstate(c); else if (!hn && mt + 1 >= eff(qul)) ns = 3;
      default: if (b) ns = vstate(c);
    endcase
    if (!e) ns = 0;
    nt = mt; nh = mh;
    if (ns != ms) begin nt = 0; nh = 0; end
    else if (ms == 1 || ms == 2) begin nh = hn; nt = mt + 1; end
    else if (ms == 3) nt = (mt + 1 >= eff(per)) ? 0 : mt + 1;
    @(posedge clk);
    ms = ns; mt = nt; mh = nh; me = int'(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, tag);
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int pulses, first;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 R10 state after reset", int'(st), 0);
    chk("R1 sync_tx", int'(tx), 0);
    chk("R1 corr_en", int'(corr), 0);
    chk("R1 master_role", int'(role), 0);

    cyc(1, 0, 0, 0, "R2");
    chk("R2 listening", int'(st), 1);
    idle(4, "R3");
    chk("R3 still listening", int'(st), 1);
    idle(1, "R3");
    chk("R3 pre-master", int'(st), 2);
    chk("R5 role", int'(role), 1);
    idle(3, "R5");
    chk("R5 still pre-master", int'(st), 2);
    chk("R5 no sync_tx", int'(tx), 0);
    idle(1, "R5");
    chk("R5 master", int'(st), 3);

    pulses = 0; first = -1;
    for (int i = 0; i < 9; i++) begin
      #1;
      if (tx) begin pulses++; if (first < 0) first = i; end
      cyc(1, 0, 0, 0, "R6");
    end
    chk("R6 pulse count", pulses, 3);
    chk("R6 first pulse cycle", first, 2);

    cyc(1, 0, 1, 1, "R8");
    chk("R8 slave", int'(st), 4);
    chk("R7 corr_en", int'(corr), 1);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, "R8 sync ignored");
    chk("R8 stays slave", int'(st), 4);
    cyc(1, 0, 1, 2, "R8");
    chk("R8 passive", int'(st), 5);
    chk("R7 corr_en off", int'(corr), 0);
    cyc(1, 0, 1, 3, "R8");
    chk("R8 disabled", int'(st), 0);
    idle(4, "R2");
    chk("R2 held disabled", int'(st), 0);
    cyc(0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    chk("R2 re-enable", int'(st), 1);

    cyc(1, 0, 1, 0, "R4");
    chk("R4 verdict ignored", int'(st), 1);
    cyc(1, 1, 0, 0, "R4");
    idle(8, "R4");
    chk("R4 no timeout", int'(st), 1);
    cyc(1, 0, 1, 1, "R4");
    chk("R4 slave by verdict", int'(st), 4);
    cyc(0, 0, 0, 0, "R9");
    chk("R9 disabled", int'(st), 0);
    cyc(1, 0, 0, 0, "R9");
    idle(5, "R9");
    chk("R9 timers cleared", int'(st), 2);
    cyc(1, 1, 1, 0, "R4");
    chk("R4 same-cycle verdict", int'(st), 3);

    cyc(0, 0, 0, 0, "R3");
    lis = 0; qul = 0; per = 0;
    cyc(1, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, "R3");
    chk("R3 zero listen", int'(st), 2);
    cyc(1, 0, 0, 0, "R5");
    chk("R5 zero qual", int'(st), 3);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R6 period one", int'(tx), 1);
      cyc(1, 0, 0, 0, "R6");
    end

    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) begin
        lis = CW'($urandom_range(0, 6));
        qul = CW'($urandom_range(0, 6));
        per = CW'($urandom_range(0, 5));
      end
      cyc(($urandom_range(0, 63) != 0), ($urandom_range(0, 9) == 0),
          ($urandom_range(0, 11) == 0), 2'($urandom_range(0, 3)), "R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule